// File: doc/BRIEF.md
# Parallel NOR Page-Read Controller

This block sits on the host side of an asynchronous parallel NOR flash that offers an eight-word page mode. A client hands it a read request: a word address, a burst length and a flag that marks the read as array or non-array (status, identifier or query space). The controller drives the byte-wide address bus, a three-wire chip-enable code and an active-low output enable. It waits the required number of system-clock cycles and captures each data word. Each word goes back to the client over a valid/ready handshake.

All waits are counted in clock cycles. Each count is the nanosecond figure rounded up to whole cycles of the clock period parameter. The controller remembers which aligned eight-word page it last read while the flash stays selected. A later array word in that page only pays the short in-page access time. A new page pays the full random access time. The flash stays selected after an array transaction, so back-to-back reads into the same page stay cheap. A non-array read deselects the flash, closes the page, and pays a bus-release gap before any reselect.

Top module: `nor_page_reader`

## Requirements
- R1: While rst_ni is low and on the first cycle after it, fl_ce_o is 3'b111, fl_oe_no is 1, rsp_valid_o is 0 and req_ready_o is 1.
- R2: fl_ce_o only ever shows 3'b000 (flash selected) or 3'b111 (deselected). fl_oe_no is low only while fl_ce_o is 3'b000.
- R3: A request with req_len_i = L returns L+1 words, for word addresses req_addr_i, req_addr_i+1, and so on, wrapping modulo 2^ADDR_W. The byte bus carries fl_addr_o = {word address, 1'b0}, and bit 0 is always 0. Each returned word is the value on fl_dq_i at the capture edge.
- R4: An array word whose page (word address bits [ADDR_W-1:3]) is not open is captured after ceil(T_ACC_NS/CLK_NS) cycles with the address stable and the flash selected. When the flash was deselected, the wait is the larger of that count and ceil(T_OE_ARR_NS/CLK_NS). The cycles are counted from the accept edge or from the previous word's handshake edge.
- R5: An array word whose page is open is captured after ceil(T_PAGE_NS/CLK_NS) cycles.
- R6: A non-array word holds fl_oe_no high for ceil(T_ACC_NS/CLK_NS) cycles after the address is presented. It then drives fl_oe_no low for ceil(T_OE_NA_NS/CLK_NS) cycles before capture. fl_oe_no returns high while that word is offered.
- R7: After an array transaction the flash stays selected, the page stays open, and fl_oe_no stays low. A following array request to the same page therefore pays the R5 wait. Accepting a non-array request closes the page.
- R8: Each time the controller deselects, fl_ce_o stays 3'b111 and fl_oe_no stays high for at least ceil(max(T_CE_REL_NS,T_OE_REL_NS)/CLK_NS) cycles before the next select. A non-array request that arrives while a page is open pays that gap before its first address phase.
- R9: While rsp_valid_o is high and rsp_ready_i is low, rsp_valid_o, rsp_data_o and fl_addr_o hold their values. The next word's access starts only at the handshake edge.
- R10: req_ready_o is high only when no transaction is in progress. It is low from the accept edge until the last word's handshake, including any trailing release gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Controller idle, request accepted on valid and ready |
| req_addr_i | input | ADDR_W | Starting word address |
| req_len_i | input | LEN_W | Number of words minus one |
| req_nonarray_i | input | 1 | 1 = status/identifier/query read, 0 = array read |
| rsp_valid_o | output | 1 | Captured word available |
| rsp_ready_i | input | 1 | Client takes the word |
| rsp_data_o | output | DATA_W | Captured word |
| fl_addr_o | output | ADDR_W+1 | Flash byte address, bit 0 held at 0 |
| fl_ce_o | output | 3 | Chip-enable code {ce2,ce1,ce0} |
| fl_oe_no | output | 1 | Flash output enable, active low |
| fl_dq_i | input | DATA_W | Flash data bus |

## Verification
The in-module assertions watch, on every cycle, that output enable is only low while the flash is selected. They also watch that a held response keeps its data and its bus address, that the idle signal never overlaps a pending word, that the wait timer never leaves zero by itself, and that a non-array accept closes the page. The actual cycle counts can only be shown by the bench scenarios. The counts to check are full access versus in-page access, the non-array output-enable phase, and the release gap before reselect. The bench uses a behavioural flash that returns garbage on any early sample. The bench sweeps every in-page start offset against every burst length, mixes in non-array reads and stalls, and compares the measured waits with counts derived from the nanosecond figures.

// File: rtl/nor_rd_pkg.sv
package nor_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REL, ST_ACC, ST_ADR, ST_OEW, ST_RSP
  } rd_state_e;

  function automatic int ns2cyc(int ns, int per);
    int c;
    c = (ns + per - 1) / per;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/nor_wait_timer.sv
module nor_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !load_i |=> done_o); // R4
endmodule

// File: rtl/nor_page_tracker.sv
module nor_page_tracker #(
  parameter int ADDR_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] cmp_addr_i,
  output logic              open_o,
  output logic              hit_o
);
  localparam int PG_W = ADDR_W - 3;

  logic            open_q;
  logic [PG_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      page_q <= '0;
    end else if (clear_i) begin
      open_q <= 1'b0;
    end else if (set_i) begin
      open_q <= 1'b1;
      page_q <= set_addr_i[ADDR_W-1:3];
    end
  end

  assign open_o = open_q;
  assign hit_o  = open_q && (cmp_addr_i[ADDR_W-1:3] == page_q);

  AST_PG_SET_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !clear_i |=> open_o && hit_o == (cmp_addr_i[ADDR_W-1:3] == $past(set_addr_i[ADDR_W-1:3]))); // R5
endmodule

// File: rtl/nor_page_reader.sv
module nor_page_reader
  import nor_rd_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int DATA_W      = 16,
  parameter int LEN_W       = 3,
  parameter int CLK_NS      = 10,
  parameter int T_ACC_NS    = 115,
  parameter int T_PAGE_NS   = 25,
  parameter int T_OE_ARR_NS = 25,
  parameter int T_OE_NA_NS  = 50,
  parameter int T_CE_REL_NS = 25,
  parameter int T_OE_REL_NS = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_nonarray_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [ADDR_W:0]   fl_addr_o,
  output logic [2:0]        fl_ce_o,
  output logic              fl_oe_no,
  input  logic [DATA_W-1:0] fl_dq_i
);
  localparam int FULL_C  = ns2cyc(T_ACC_NS, CLK_NS);
  localparam int PAGE_C  = ns2cyc(T_PAGE_NS, CLK_NS);
  localparam int OEA_C   = ns2cyc(T_OE_ARR_NS, CLK_NS);
  localparam int OEN_C   = ns2cyc(T_OE_NA_NS, CLK_NS);
  localparam int REL_C   = ns2cyc(imax(T_CE_REL_NS, T_OE_REL_NS), CLK_NS);
  localparam int FIRST_C = imax(FULL_C, OEA_C);
  localparam int MAX_C   = imax(imax(FIRST_C, PAGE_C), imax(OEN_C, REL_C));
  localparam int CNT_W   = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] FULL_L  = CNT_W'(FULL_C - 1);
  localparam logic [CNT_W-1:0] PAGE_L  = CNT_W'(PAGE_C - 1);
  localparam logic [CNT_W-1:0] OEN_L   = CNT_W'(OEN_C - 1);
  localparam logic [CNT_W-1:0] REL_L   = CNT_W'(REL_C - 1);
  localparam logic [CNT_W-1:0] FIRST_L = CNT_W'(FIRST_C - 1);

  rd_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, cmp_addr;
  logic [LEN_W-1:0]  left_q;
  logic              na_q, pend_q;
  logic [DATA_W-1:0] data_q;
  logic              ld, tmr_done, pg_set, pg_clr, pg_open, pg_hit;
  logic              accept, advance, cap, rel_exit;
  logic [CNT_W-1:0]  ld_val;
  logic              sel, oe_low;

  nor_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld), .load_val_i(ld_val), .done_o(tmr_done)
  );

  nor_page_tracker #(.ADDR_W(ADDR_W)) u_page (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(pg_set), .set_addr_i(addr_q),
    .clear_i(pg_clr), .cmp_addr_i(cmp_addr), .open_o(pg_open), .hit_o(pg_hit)
  );

  always_comb begin
    state_d  = state_q;
    ld       = 1'b0;
    ld_val   = '0;
    pg_set   = 1'b0;
    pg_clr   = 1'b0;
    cap      = 1'b0;
    accept   = 1'b0;
    advance  = 1'b0;
    rel_exit = 1'b0;
    cmp_addr = addr_q + 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        cmp_addr = req_addr_i;
        if (req_valid_i) begin
          accept = 1'b1;
          ld     = 1'b1;
          if (req_nonarray_i) begin
            pg_clr = 1'b1;
            if (pg_open) begin state_d = ST_REL; ld_val = REL_L;  end
            else         begin state_d = ST_ADR; ld_val = FULL_L; end
          end else begin
            state_d = ST_ACC;
            ld_val  = pg_hit ? PAGE_L : FIRST_L;
          end
        end
      end
      ST_REL: if (tmr_done) begin
        rel_exit = 1'b1;
        if (pend_q) begin state_d = ST_ADR; ld = 1'b1; ld_val = FULL_L; end
        else        state_d = ST_IDLE;
      end
      ST_ADR: if (tmr_done) begin state_d = ST_OEW; ld = 1'b1; ld_val = OEN_L; end
      ST_OEW: if (tmr_done) begin state_d = ST_RSP; cap = 1'b1; end
      ST_ACC: if (tmr_done) begin state_d = ST_RSP; cap = 1'b1; pg_set = 1'b1; end
      ST_RSP: if (rsp_ready_i) begin
        if (left_q == '0) begin
          if (na_q) begin state_d = ST_REL; ld = 1'b1; ld_val = REL_L; end
          else      state_d = ST_IDLE;
        end else begin
          advance = 1'b1;
          ld      = 1'b1;
          if (na_q) begin state_d = ST_ADR; ld_val = FULL_L; end
          else begin
            state_d = ST_ACC;
            ld_val  = pg_hit ? PAGE_L : FULL_L;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      na_q    <= 1'b0;
      pend_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= req_addr_i;
        left_q <= req_len_i;
        na_q   <= req_nonarray_i;
        pend_q <= req_nonarray_i && pg_open;
      end else if (advance) begin
        addr_q <= addr_q + 1'b1;
        left_q <= left_q - 1'b1;
      end
      if (rel_exit) pend_q <= 1'b0;
      if (cap)      data_q <= fl_dq_i;
    end
  end

  assign sel = (state_q inside {ST_ACC, ST_ADR, ST_OEW, ST_RSP}) || (state_q == ST_IDLE && pg_open);
  assign oe_low = (state_q == ST_ACC) || (state_q == ST_OEW) ||
                  (state_q == ST_RSP && !na_q) || (state_q == ST_IDLE && pg_open);

  assign fl_ce_o     = sel ? 3'b000 : 3'b111;
  assign fl_oe_no    = !oe_low;
  assign fl_addr_o   = {addr_q, 1'b0};
  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RSP);
  assign rsp_data_o  = data_q;

  AST_OE_ONLY_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_no |-> fl_ce_o == 3'b000); // R2
  AST_RSP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o) && $stable(fl_addr_o)); // R9
  AST_IDLE_NO_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !rsp_valid_o); // R10
  AST_NA_CLOSES_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_nonarray_i |=> !pg_open); // R7
endmodule

// File: tb/nor_page_reader_bench.sv
module nor_page_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int LW = 3;

  localparam int FULL_C  = (115 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int PAGE_C  = (25 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int OEA_C   = (25 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int OEN_C   = (50 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int REL_C   = (25 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int FIRST_C = (FULL_C > OEA_C) ? FULL_C : OEA_C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_na = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data, dq;
  logic [AW:0] fl_addr;
  logic [2:0] fl_ce;
  logic fl_oe_n;

  int checks = 0, fails = 0;
  int open_pg = -1;
  bit cur_na = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_page_reader #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .CLK_NS(CLK_PERIOD)) u_nor_page_reader (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_nonarray_i(req_na),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data),
    .fl_addr_o(fl_addr), .fl_ce_o(fl_ce), .fl_oe_no(fl_oe_n), .fl_dq_i(dq)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] arr_word(int a);
    return {~a[7:0], a[7:0]};
  endfunction
  function automatic logic [DW-1:0] na_word(int a);
    return {a[7:0], ~a[7:0]} ^ 16'h5A5A;
  endfunction

  // behavioural flash: returns garbage until each timing window has elapsed
  logic [AW:0] p_addr = '0;
  logic p_sel = 1'b0, p_oe = 1'b0;
  int c_full = 0, c_pg = 0, c_oe = 0, cyc = 0, desel_cyc = -1000;
  logic sel_now, oe_now;
  int e_full, e_pg, e_oe;

  assign sel_now = (fl_ce == 3'b000);
  assign oe_now  = sel_now && !fl_oe_n;

  always_comb begin
    e_full = (!sel_now || !p_sel || fl_addr[AW:4] != p_addr[AW:4]) ? 0 : c_full;
    e_pg   = (!sel_now || !p_sel || fl_addr != p_addr) ? 0 : c_pg;
    e_oe   = (!oe_now || !p_oe) ? 0 : c_oe;
    dq = 16'hDEAD;
    if (sel_now && oe_now) begin
      if (cur_na) begin
        if (e_pg + 1 >= FULL_C && e_oe + 1 >= OEN_C) dq = na_word(int'(fl_addr[AW:1]));
      end else begin
        if (e_full + 1 >= FULL_C && e_pg + 1 >= PAGE_C && e_oe + 1 >= OEA_C)
          dq = arr_word(int'(fl_addr[AW:1]));
      end
    end
  end

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    p_addr <= fl_addr;
    p_sel  <= sel_now;
    p_oe   <= oe_now;
    c_full <= e_full + 1;
    c_pg   <= e_pg + 1;
    c_oe   <= e_oe + 1;
    if (rst_n && !sel_now && p_sel) desel_cyc <= cyc;
    if (rst_n && sel_now && !p_sel && desel_cyc > -1000)
      chk(cyc - desel_cyc >= REL_C, "R8 release gap", cyc - desel_cyc, REL_C);
  end

  task automatic do_read(int a0, int len, bit na, bit stall);
    @(negedge clk);
    req_addr  = a0[AW-1:0];
    req_len   = len[LW-1:0];
    req_na    = na;
    req_valid = 1'b1;
    rsp_ready = !stall;
    while (!req_ready) @(negedge clk);
    cur_na = na;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10 busy after accept", req_ready, 0);
    for (int i = 0; i <= len; i++) begin
      int a, n, exp_w;
      logic [DW-1:0] held;
      a = (a0 + i) & ((1 << AW) - 1);
      if (na) exp_w = FULL_C + OEN_C + ((i == 0 && open_pg >= 0) ? REL_C : 0);
      else if (open_pg == (a >> 3)) exp_w = PAGE_C;
      else exp_w = (i == 0 && open_pg < 0) ? FIRST_C : FULL_C;
      if (na && i == 0) open_pg = -1;
      n = 0;
      while (!rsp_valid && n < 100) begin @(posedge clk); n++; @(negedge clk); end
      if (na) chk(n == exp_w, (i == 0 && exp_w > FULL_C + OEN_C) ? "R8 R6 wait" : "R6 non-array wait", n, exp_w);
      else if (exp_w == PAGE_C) chk(n == exp_w, "R5 in-page wait", n, exp_w);
      else chk(n == exp_w, "R4 full wait", n, exp_w);
      chk(rsp_data == (na ? na_word(a) : arr_word(a)), "R3 data", rsp_data, na ? na_word(a) : arr_word(a));
      chk(fl_addr == {a[AW-1:0], 1'b0}, "R3 byte address", fl_addr, {a[AW-1:0], 1'b0});
      chk(fl_ce == 3'b000, "R2 select code", fl_ce, 0);
      if (na) chk(fl_oe_n, "R6 oe high while offered", fl_oe_n, 1);
      if (!na) open_pg = a >> 3;
      if (stall) begin
        held = rsp_data;
        @(posedge clk); @(negedge clk);
        chk(rsp_valid && rsp_data == held && fl_addr == {a[AW-1:0], 1'b0}, "R9 hold under stall", rsp_data, held);
        rsp_ready = 1'b1;
      end
      @(posedge clk); @(negedge clk);
      if (stall) rsp_ready = 1'b0;
    end
    rsp_ready = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    chk(fl_ce == 3'b111 && fl_oe_n && !rsp_valid && req_ready, "R1 reset outputs",
        {fl_ce, fl_oe_n, rsp_valid, req_ready}, 6'b111101);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fl_ce == 3'b111 && fl_oe_n && !rsp_valid && req_ready, "R1 after reset",
        {fl_ce, fl_oe_n, rsp_valid, req_ready}, 6'b111101);

    // sweep every in-page start offset against every burst length
    for (int s = 0; s < 8; s++) begin
      for (int l = 0; l < 8; l++) begin
        int base = ((s * 3 + l) % 5) * 8 + s;
        do_read(base, l, 1'b0, l == 5);
        if (l == 3) do_read(base + 17, s % 3, 1'b1, s == 2);
      end
    end

    // R7: page kept open across transactions, closed by a non-array read
    do_read(40, 0, 1'b0, 1'b0);
    chk(fl_ce == 3'b000 && !fl_oe_n, "R7 stays selected", {fl_ce, fl_oe_n}, 0);
    do_read(45, 1, 1'b0, 1'b0);
    do_read(8, 0, 1'b1, 1'b0);
    chk(fl_ce == 3'b111 || req_ready == 1'b0, "R7 page closed", fl_ce, 7);
    do_read(41, 0, 1'b0, 1'b0);
    // crossing a page in one burst, and wrap at the top of the space
    do_read(6, 3, 1'b0, 1'b0);
    do_read(254, 3, 1'b0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule